// File: doc/BRIEF.md
# AUX Request Byte Sequencer

This block converts one DisplayPort AUX request into the ordered bytes that fill the transmit buffer. A request is described by three flags (I2C-over-AUX, write, middle-of-transaction), a 20-bit address and a byte length. It also uses payload bytes that were written into a small internal buffer before the request started. On a start pulse in idle, the block latches the request and reports the total transmit byte count. It then hands out one byte per valid/ready handshake.

The header packs the command nibble together with the upper address nibble. The two lower address bytes follow. A length byte is sent only when the length is nonzero, and it is coded as length minus one. Writes then append their payload in index order. Reads send only the header. A request longer than the buffer is refused with an error pulse, and no bytes are emitted for it.

Top module: `aux_req_sequencer`

## Requirements
- R1: The command nibble is {~i2c, i2c & mot, 0, ~write}. This gives native write 0x8, native read 0x9, I2C write 0x0, I2C read 0x1, I2C write with mot 0x4 and I2C read with mot 0x5. Native requests ignore mot.
- R2: Byte 0 is {command, addr[19:16]}, byte 1 is addr[15:8] and byte 2 is addr[7:0].
- R3: When the length is nonzero, byte 3 is length minus one. When the length is zero, no length byte is sent.
- R4: One cycle after a start is accepted, cnt_valid_o pulses for one cycle. From that cycle until the next accepted start, tx_count_o holds (length ? 4 : 3) + (write ? length : 0).
- R5: Writes send payload bytes 0 to length-1 in index order after the header. Reads send no payload.
- R6: tx_valid_o stays high and tx_byte_o stays unchanged while tx_ready_i is low. Exactly one byte advances per cycle with both signals high.
- R7: done_o pulses for one cycle, one cycle after the last byte is handed off. In that cycle the block is idle and accepts a new start.
- R8: A start pulse while busy has no effect on the bytes, the count or the completion of the request in progress.
- R9: A start with length above MAX_LEN raises err_o for one cycle, one cycle later. No count pulse and no bytes are emitted, and the block stays idle.
- R10: Payload buffer writes are applied only while idle. Writes during a request are dropped.
- R11: After reset the block is idle, with tx_valid_o, cnt_valid_o, done_o, err_o and busy_o low and tx_count_o zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request start pulse |
| i2c_i | input | 1 | Request is I2C-over-AUX |
| write_i | input | 1 | Request is a write |
| mot_i | input | 1 | Middle-of-transaction flag (I2C only) |
| addr_i | input | 20 | Request address |
| len_i | input | LEN_W | Request byte length |
| pl_we_i | input | 1 | Payload buffer write enable |
| pl_idx_i | input | IDX_W | Payload buffer write index |
| pl_data_i | input | 8 | Payload buffer write data |
| tx_ready_i | input | 1 | Consumer accepts a byte |
| tx_valid_o | output | 1 | Byte available |
| tx_byte_o | output | 8 | Current byte |
| cnt_valid_o | output | 1 | Count valid pulse |
| tx_count_o | output | TOT_W | Total transmit byte count |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Length rejection pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one request and the acceptance of the next start. The bench provokes this by chaining every second request. It raises start_i in the very cycle where it sees done_o high. The bench then requires the count pulse and the first header byte of the new request to appear one cycle later, with no gap. The bench also checks that a start raised mid-stream, and buffer writes made during the same stall, leave both the remaining bytes and the count unchanged.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } seq_state_e;

    localparam int ADDR_W = 20;
    localparam int HDR_BYTES = 3;
endpackage

// File: rtl/aux_cmd_encode.sv
module aux_cmd_encode (
    input  logic       i2c_i,
    input  logic       write_i,
    input  logic       mot_i,
    output logic [3:0] cmd_o
);
    always_comb begin
        cmd_o[3] = ~i2c_i;
        cmd_o[2] = i2c_i & mot_i;
        cmd_o[1] = 1'b0;
        cmd_o[0] = ~write_i;
    end
endmodule

// File: rtl/aux_payload_buf.sv
module aux_payload_buf #(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [7:0]       wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [7:0]       rdata_o
);
    logic [7:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [7:0] ent_d;
        always_comb begin
            ent_d = mem_q[g];
            if (we_i && (widx_i == IDX_W'(g))) begin
                ent_d = wdata_i;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= ent_d;
            end
        end
    end

    assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/aux_byte_select.sv
module aux_byte_select #(
    parameter int LEN_W = 5,
    parameter int TOT_W = 5,
    parameter int IDX_W = 4
) (
    input  logic [TOT_W-1:0] idx_i,
    input  logic [3:0]       cmd_i,
    input  logic [19:0]      addr_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [7:0]       pl_byte_i,
    output logic [IDX_W-1:0] pl_ridx_o,
    output logic [7:0]       byte_o
);
    logic [TOT_W-1:0] hdr_len;

    always_comb begin
        hdr_len   = (len_i != '0) ? TOT_W'(4) : TOT_W'(3);
        pl_ridx_o = IDX_W'(idx_i - hdr_len);
        if (idx_i == TOT_W'(0)) begin
            byte_o = {cmd_i, addr_i[19:16]};
        end else if (idx_i == TOT_W'(1)) begin
            byte_o = addr_i[15:8];
        end else if (idx_i == TOT_W'(2)) begin
            byte_o = addr_i[7:0];
        end else if ((idx_i == TOT_W'(3)) && (len_i != '0)) begin
            byte_o = 8'(len_i - LEN_W'(1));
        end else begin
            byte_o = pl_byte_i;
        end
    end
endmodule

// File: rtl/aux_req_sequencer.sv
module aux_req_sequencer
    import aux_seq_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    parameter int IDX_W   = $clog2(MAX_LEN),
    parameter int TOT_W   = $clog2(MAX_LEN + HDR_BYTES + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             i2c_i,
    input  logic             write_i,
    input  logic             mot_i,
    input  logic [19:0]      addr_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             pl_we_i,
    input  logic [IDX_W-1:0] pl_idx_i,
    input  logic [7:0]       pl_data_i,
    input  logic             tx_ready_i,
    output logic             tx_valid_o,
    output logic [7:0]       tx_byte_o,
    output logic             cnt_valid_o,
    output logic [TOT_W-1:0] tx_count_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [3:0]       cmd;
        logic [19:0]      addr;
        logic [LEN_W-1:0] len;
        logic [TOT_W-1:0] idx;
        logic [TOT_W-1:0] total;
        logic             cnt_vld;
        logic             done;
        logic             err;
    } seq_reg_t;

    seq_reg_t         r_d, r_q;
    logic [3:0]       cmd_w;
    logic [IDX_W-1:0] pl_ridx;
    logic [7:0]       pl_byte;
    logic [7:0]       sel_byte;
    logic [TOT_W-1:0] total_w;
    logic             idle_w;

    assign idle_w = (r_q.state == ST_IDLE);

    aux_cmd_encode u_cmd (
        .i2c_i   (i2c_i),
        .write_i (write_i),
        .mot_i   (mot_i),
        .cmd_o   (cmd_w)
    );

    aux_payload_buf #(
        .DEPTH (MAX_LEN),
        .IDX_W (IDX_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (pl_we_i && idle_w),
        .widx_i  (pl_idx_i),
        .wdata_i (pl_data_i),
        .ridx_i  (pl_ridx),
        .rdata_o (pl_byte)
    );

    aux_byte_select #(
        .LEN_W (LEN_W),
        .TOT_W (TOT_W),
        .IDX_W (IDX_W)
    ) u_sel (
        .idx_i     (r_q.idx),
        .cmd_i     (r_q.cmd),
        .addr_i    (r_q.addr),
        .len_i     (r_q.len),
        .pl_byte_i (pl_byte),
        .pl_ridx_o (pl_ridx),
        .byte_o    (sel_byte)
    );

    always_comb begin
        total_w = ((len_i != '0) ? TOT_W'(4) : TOT_W'(3))
                + (write_i ? TOT_W'(len_i) : TOT_W'(0));
        r_d         = r_q;
        r_d.cnt_vld = 1'b0;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (len_i > LEN_W'(MAX_LEN)) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.state   = ST_SEND;
                        r_d.cmd     = cmd_w;
                        r_d.addr    = addr_i;
                        r_d.len     = len_i;
                        r_d.idx     = '0;
                        r_d.total   = total_w;
                        r_d.cnt_vld = 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (tx_ready_i) begin
                    if (r_q.idx == r_q.total - TOT_W'(1)) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + TOT_W'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid_o  = (r_q.state == ST_SEND);
    assign tx_byte_o   = sel_byte;
    assign cnt_valid_o = r_q.cnt_vld;
    assign tx_count_o  = r_q.total;
    assign busy_o      = ~idle_w;
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_byte_o));

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(tx_valid_o && tx_ready_i) && !busy_o);

    // R9
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !tx_valid_o && !cnt_valid_o && !busy_o);

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && $past(tx_valid_o) |-> $stable(tx_count_o));

    // R4
    count_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid_o |-> tx_valid_o && $past(start_i && !busy_o));

    // R7
    pulses_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, err_o, cnt_valid_o}));
endmodule

// File: tb/aux_req_sequencer_test.sv
module aux_req_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN = 16;
    localparam int LEN_W = 5;
    localparam int IDX_W = 4;
    localparam int TOT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             i2c_i = 1'b0;
    logic             write_i = 1'b0;
    logic             mot_i = 1'b0;
    logic [19:0]      addr_i = '0;
    logic [LEN_W-1:0] len_i = '0;
    logic             pl_we_i = 1'b0;
    logic [IDX_W-1:0] pl_idx_i = '0;
    logic [7:0]       pl_data_i = '0;
    logic             tx_ready_i = 1'b0;
    logic             tx_valid_o;
    logic [7:0]       tx_byte_o;
    logic             cnt_valid_o;
    logic [TOT_W-1:0] tx_count_o;
    logic             busy_o;
    logic             done_o;
    logic             err_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [3:0]  e_cmd;
    logic [19:0] e_addr;
    int          e_len;
    bit          e_wr;
    int          e_seed;

    aux_req_sequencer #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .i2c_i(i2c_i),
        .write_i(write_i), .mot_i(mot_i), .addr_i(addr_i), .len_i(len_i),
        .pl_we_i(pl_we_i), .pl_idx_i(pl_idx_i), .pl_data_i(pl_data_i),
        .tx_ready_i(tx_ready_i), .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o),
        .cnt_valid_o(cnt_valid_o), .tx_count_o(tx_count_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int i, int s);
        return 8'(i * 37 + s * 11 + 5);
    endfunction

    function automatic int exp_total();
        return (e_len != 0 ? 4 : 3) + (e_wr ? e_len : 0);
    endfunction

    function automatic logic [7:0] exp_byte(int k);
        int hdr = (e_len != 0) ? 4 : 3;
        if (k == 0) return {e_cmd, e_addr[19:16]};
        if (k == 1) return e_addr[15:8];
        if (k == 2) return e_addr[7:0];
        if (k == 3 && e_len != 0) return 8'(e_len - 1);
        return pat(k - hdr, e_seed);
    endfunction

    task automatic load_buf(int seed);
        for (int i = 0; i < MAX_LEN; i++) begin
            pl_we_i = 1'b1;
            pl_idx_i = IDX_W'(i);
            pl_data_i = pat(i, seed);
            @(negedge clk);
        end
        pl_we_i = 1'b0;
    endtask

    task automatic start_req(bit i2c, bit wr, bit mot, logic [19:0] addr, int len, int seed);
        if (i2c) e_cmd = {1'b0, mot, 1'b0, ~wr};
        else     e_cmd = {3'b100, ~wr};
        e_addr = addr; e_len = len; e_wr = wr; e_seed = seed;
        i2c_i = i2c; write_i = wr; mot_i = mot; addr_i = addr; len_i = LEN_W'(len);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(cnt_valid_o == 1'b1, "R4 count pulse", cnt_valid_o, 1);
        chk(int'(tx_count_o) == exp_total(), "R4 byte count", tx_count_o, exp_total());
    endtask

    task automatic stream(bit stall, bit inject);
        int  k = 0;
        int  step = 0;
        bit  injected = 1'b0;
        bit  rdy;
        int  tot = exp_total();
        while (k < tot) begin
            chk(tx_valid_o == 1'b1, "R6 valid during stream", tx_valid_o, 1);
            if (k < 3)
                chk(tx_byte_o == exp_byte(k), "R1 R2 header byte", tx_byte_o, exp_byte(k));
            else if (k == 3 && e_len != 0)
                chk(tx_byte_o == exp_byte(k), "R3 length byte", tx_byte_o, exp_byte(k));
            else
                chk(tx_byte_o == exp_byte(k), "R5 R10 payload byte", tx_byte_o, exp_byte(k));
            rdy = stall ? (((step * 3 + e_seed) % 4) != 0) : 1'b1;
            step++;
            if (inject && k == 1 && !injected) begin
                start_i = 1'b1;
                len_i = LEN_W'(2);
                addr_i = ~e_addr;
                write_i = ~e_wr;
                pl_we_i = 1'b1;
                pl_idx_i = IDX_W'(e_len - 1);
                pl_data_i = ~pat(e_len - 1, e_seed);
                injected = 1'b1;
            end
            tx_ready_i = rdy;
            @(negedge clk);
            start_i = 1'b0;
            pl_we_i = 1'b0;
            if (rdy) k++;
        end
        tx_ready_i = 1'b0;
        chk(done_o == 1'b1, "R7 done pulse", done_o, 1);
        chk(tx_valid_o == 1'b0, "R7 idle after last", tx_valid_o, 0);
        chk(int'(tx_count_o) == tot, "R8 count unchanged", tx_count_o, tot);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(tx_valid_o == 1'b0, "R11 valid", tx_valid_o, 0);
        chk(busy_o == 1'b0, "R11 busy", busy_o, 0);
        chk(done_o == 1'b0, "R11 done", done_o, 0);
        chk(err_o == 1'b0, "R11 err", err_o, 0);
        chk(cnt_valid_o == 1'b0, "R11 cnt_valid", cnt_valid_o, 0);
        chk(tx_count_o == '0, "R11 count", tx_count_o, 0);

        // R9 oversize lengths
        for (int ln = MAX_LEN + 1; ln < 32; ln += 7) begin
            i2c_i = 1'b0; write_i = 1'b1; len_i = LEN_W'(ln); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(err_o == 1'b1, "R9 err pulse", err_o, 1);
            chk(tx_valid_o == 1'b0, "R9 no bytes", tx_valid_o, 0);
            chk(cnt_valid_o == 1'b0, "R9 no count", cnt_valid_o, 0);
            @(negedge clk);
            chk(err_o == 1'b0, "R9 single pulse", err_o, 0);
            chk(busy_o == 1'b0, "R9 stays idle", busy_o, 0);
        end

        // R1..R8, R10 sweep; odd trials start in the done cycle (R7)
        for (int t = 0; t < 40; t++) begin
            int  f = t / 5;
            int  li = t % 5;
            int  lens[5] = '{0, 1, 2, 5, 16};
            int  len = lens[li];
            bit  i2c = f[2];
            bit  wr = f[1];
            bit  mot = f[0];
            logic [19:0] addr = 20'(f * 32'h1357 + li * 32'h2468 + 32'hA5A5A);
            int  seed = t / 2;
            if (t % 2 == 0) load_buf(seed);
            start_req(i2c, wr, mot, addr, len, seed);
            stream(((f + li) % 2) == 1, wr && (li == 3));
        end

        @(negedge clk);
        chk(busy_o == 1'b0, "R7 final idle", busy_o, 0);
        summary();
        $finish;
    end
endmodule